// File: doc/BRIEF.md
# Backplane Slot-Priority Arbiter

This block is the central arbiter of a repeater built from several boards that share one backplane. Each board slot has one active-low request line. A board pulls its line low when one of its ports starts receiving while the repeater is idle. The arbiter picks the requesting slot with the lowest slot number and drives that slot's binary number onto a shared arbitration bus, together with a valid strobe. Every board compares the bus value with its own slot number to learn whether it holds the port that is being repeated.

The same selection runs again when the repeater enters its transmit-collision phase. Priority follows physical position only, so an empty slot has no effect: its request line simply stays high.

The winner is captured when arbitration takes place and stays on the bus until every request has gone away. A new winner is chosen only when the transmit-collision phase begins, or after the repeater returns to idle. The request lines come from other boards and are asynchronous, so each line passes through a synchronizer before it reaches the decision logic.

Top module: `slot_arb_top`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `arb_valid` is 0 and `arb_id` is 0.
- R2: A request line counts as asserted while it is low. With the default of two synchronizer stages, a request made on an idle, unheld bus shows on `arb_valid` exactly three clock edges after the line falls, and not before.
- R3: When a selection is made, `arb_id` carries the binary index of the lowest-numbered slot whose line is low. Slot 0 has the highest priority.
- R4: A new selection starts only while `rpt_idle` or `xmit_coll` is high. Requests that arrive while both are low leave `arb_valid` at 0.
- R5: Once a winner is on the bus, `arb_id` stays unchanged as long as any request remains. This holds when the repeater leaves idle and when a lower-numbered slot starts requesting later.
- R6: When all request lines are high after synchronization, `arb_valid` drops to 0 on the next edge.
- R7: A rising edge of `xmit_coll` while a winner is held picks a new winner from the current synchronized requests. The new winner is on the bus one edge later and `arb_valid` stays 1.
- R8: A rising edge of `rpt_idle` while a winner is held drops `arb_valid` for exactly one cycle. If requests remain, a fresh selection follows on the next edge.
- R9: Whenever `arb_valid` is 0, `arb_id` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | NUM_SLOTS | Active-low request line per slot; bit i belongs to slot i |
| rpt_idle | input | 1 | High while the repeater is in its idle phase |
| xmit_coll | input | 1 | High while the repeater is in its transmit-collision phase |
| arb_id | output | ID_W | Binary slot number of the current winner |
| arb_valid | output | 1 | High while `arb_id` names a held winner |

## Verification
Most faults inside the arbiter show at the ports within one or two edges of the event that exposes them. A wrong priority order puts the wrong number on `arb_id` on the very edge where the selection is made. A hold state that fails to latch shows up differently: `arb_id` follows a later request from a lower-numbered slot. A missed edge detector shows as a winner that survives a collision restart, or as a missing one-cycle gap in `arb_valid` when idle returns. A synchronizer of the wrong depth moves the first `arb_valid` off its third edge. The bench checks each of these at the exact cycle as well as in steady state after randomized request patterns.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  typedef enum logic [0:0] {
    ARB_FREE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

endpackage

// File: rtl/slot_req_sync.sv
// Multi-stage synchronizer for the asynchronous backplane request lines.
// The input is already active-high here; reset clears every stage.
module slot_req_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign synced = raw;
    end else begin : g_pipe
      logic [N-1:0] pipe [STAGES];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < STAGES; s++) begin
            pipe[s] <= '0;
          end
        end else begin
          pipe[0] <= raw;
          for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
          end
        end
      end

      assign synced = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/slot_prio_enc.sv
// Fixed-priority encoder: the lowest set index wins.
module slot_prio_enc #(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    act,
  output logic            any,
  output logic [ID_W-1:0] id
);

  logic [N:0]   seen;
  logic [N-1:0] grant;
  logic [N-1:0] below_mask;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      assign seen[i+1] = seen[i] | act[i];
      assign grant[i]  = act[i] & ~seen[i];
    end
  endgenerate

  always_comb begin
    id = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) id = id | ID_W'(i);
    end
  end

  assign any        = seen[N];
  assign below_mask = (N'(1) << id) - N'(1);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)) else $error("more than one grant"); // R3

  AST_WINNER_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    any |-> act[id]) else $error("encoded slot is not requesting"); // R3

  AST_NONE_BELOW: assert property (@(posedge clk) disable iff (rst)
    any |-> ((act & below_mask) == '0)) else $error("lower slot skipped"); // R3

endmodule

// File: rtl/slot_arb_ctrl.sv
// Hold controller: captures a winner, holds it, and restarts on phase edges.
module slot_arb_ctrl
  import slot_arb_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act_any,
  input  logic [ID_W-1:0] enc_id,
  input  logic            rpt_idle,
  input  logic            xmit_coll,
  output logic [ID_W-1:0] id_q,
  output logic            valid_q
);

  arb_state_e state;
  logic       idle_q;
  logic       coll_q;
  logic       idle_rise;
  logic       coll_rise;
  logic       may_start;

  assign idle_rise = rpt_idle & ~idle_q;
  assign coll_rise = xmit_coll & ~coll_q;
  assign may_start = act_any & (rpt_idle | xmit_coll);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ARB_FREE;
      id_q    <= '0;
      valid_q <= 1'b0;
      idle_q  <= 1'b1;
      coll_q  <= 1'b0;
    end else begin
      idle_q <= rpt_idle;
      coll_q <= xmit_coll;
      unique case (state)
        ARB_FREE: begin
          if (may_start) begin
            state   <= ARB_HELD;
            id_q    <= enc_id;
            valid_q <= 1'b1;
          end else begin
            id_q    <= '0;
            valid_q <= 1'b0;
          end
        end
        ARB_HELD: begin
          if (!act_any || idle_rise) begin
            state   <= ARB_FREE;
            id_q    <= '0;
            valid_q <= 1'b0;
          end else if (coll_rise) begin
            id_q <= enc_id;
          end
        end
        default: begin
          state   <= ARB_FREE;
          id_q    <= '0;
          valid_q <= 1'b0;
        end
      endcase
    end
  end

  AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (id_q == '0)) else $error("id not zero while invalid"); // R9

  AST_START_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> ($past(rpt_idle) || $past(xmit_coll))) else $error("start outside phase"); // R4

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(act_any)) else $error("start with no request"); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(valid_q) && !$past(coll_rise)) |-> $stable(id_q)) else $error("held id moved"); // R5

  AST_DROP_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !$past(act_any) |-> !valid_q) else $error("valid without requests"); // R6

  AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (rst)
    $past(valid_q && idle_rise) |-> !valid_q) else $error("no gap on idle return"); // R8

endmodule

// File: rtl/slot_arb_top.sv
module slot_arb_top #(
  parameter int NUM_SLOTS   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ID_W        = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] req_n,
  input  logic                 rpt_idle,
  input  logic                 xmit_coll,
  output logic [ID_W-1:0]      arb_id,
  output logic                 arb_valid
);

  logic [NUM_SLOTS-1:0] req_raw;
  logic [NUM_SLOTS-1:0] req_act;
  logic                 any_req;
  logic [ID_W-1:0]      top_id;

  assign req_raw = ~req_n;

  slot_req_sync #(
    .N      (NUM_SLOTS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (req_raw),
    .synced (req_act)
  );

  slot_prio_enc #(
    .N    (NUM_SLOTS),
    .ID_W (ID_W)
  ) u_enc (
    .clk (clk),
    .rst (rst),
    .act (req_act),
    .any (any_req),
    .id  (top_id)
  );

  slot_arb_ctrl #(
    .ID_W (ID_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .act_any   (any_req),
    .enc_id    (top_id),
    .rpt_idle  (rpt_idle),
    .xmit_coll (xmit_coll),
    .id_q      (arb_id),
    .valid_q   (arb_valid)
  );

endmodule

// File: tb/test_slot_arb_top.sv
module test_slot_arb_top;

  localparam int N    = 16;
  localparam int ID_W = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    req_n;
  logic            rpt_idle;
  logic            xmit_coll;
  logic [ID_W-1:0] arb_id;
  logic            arb_valid;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  slot_arb_top #(.NUM_SLOTS(N), .SYNC_STAGES(2)) i_slot_arb_top (
    .clk       (clk),
    .rst       (rst),
    .req_n     (req_n),
    .rpt_idle  (rpt_idle),
    .xmit_coll (xmit_coll),
    .arb_id    (arb_id),
    .arb_valid (arb_valid)
  );

  function automatic logic [ID_W-1:0] lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) begin
      if (m[i]) return ID_W'(i);
    end
    return '0;
  endfunction

  function automatic logic [N-1:0] rand_mask();
    logic [N-1:0] m;
    m = N'($urandom());
    if ($urandom_range(0, 2) == 0) m = N'(1) << $urandom_range(0, N-1);
    if (m == '0) m = N'(1) << (N-1);
    return m;
  endfunction

  task automatic check(input string req, input logic exp_v, input logic [ID_W-1:0] exp_id);
    n_checks++;
    if (arb_valid !== exp_v || arb_id !== exp_id) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               req, arb_valid, arb_id, exp_v, exp_id);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [N-1:0] m1, m2, m3;
    void'($urandom(32'd20240611));
    rst = 1'b1; req_n = '1; rpt_idle = 1'b1; xmit_coll = 1'b0;
    cyc(3);
    check("R1 in reset", 1'b0, '0);
    rst = 1'b0;
    cyc(1);
    check("R1 after reset", 1'b0, '0);

    // R2: exact latency of three edges
    req_n = ~16'h0120;
    cyc(2);
    check("R2 before latency", 1'b0, '0);
    cyc(1);
    check("R2 at latency R3", 1'b1, 4'd5);
    // R5: lower slot arrives later, winner kept
    rpt_idle = 1'b0;
    req_n = ~16'h0121;
    cyc(4);
    check("R5 later lower slot", 1'b1, 4'd5);
    req_n = '1;
    cyc(3);
    check("R6 release", 1'b0, '0);

    // Corner: only the last slot, then every slot
    rpt_idle = 1'b1;
    req_n = ~16'h8000;
    cyc(4);
    check("R3 last slot only", 1'b1, 4'd15);
    req_n = '1;
    cyc(4);
    check("R6 release last", 1'b0, '0);
    req_n = '0;
    cyc(4);
    check("R3 all slots", 1'b1, 4'd0);
    req_n = '1;
    cyc(4);
    check("R9 id zero when idle", 1'b0, '0);

    for (int ep = 0; ep < 60; ep++) begin
      m1 = rand_mask();
      rpt_idle = 1'b1; xmit_coll = 1'b0;
      req_n = ~m1;
      cyc(4);
      check("R3 idle selection", 1'b1, lowest(m1));
      rpt_idle = 1'b0;
      m2 = m1 | N'($urandom());
      req_n = ~m2;
      cyc(4);
      check("R5 hold while busy", 1'b1, lowest(m1));
      m3 = rand_mask();
      req_n = ~m3;
      cyc(4);
      check("R5 hold after change", 1'b1, lowest(m1));
      xmit_coll = 1'b1;
      cyc(1);
      check("R7 collision reselect", 1'b1, lowest(m3));
      cyc(2);
      xmit_coll = 1'b0;
      cyc(1);
      check("R5 hold after collision", 1'b1, lowest(m3));
      req_n = '1;
      cyc(3);
      check("R6 all released", 1'b0, '0);

      // R4: busy phase ignores new requests
      m1 = rand_mask();
      req_n = ~m1;
      cyc(5);
      check("R4 ignored while busy", 1'b0, '0);
      rpt_idle = 1'b1;
      cyc(1);
      check("R4 start on idle", 1'b1, lowest(m1));
      rpt_idle = 1'b0;
      cyc(1);
      rpt_idle = 1'b1;
      cyc(1);
      check("R8 gap on idle return", 1'b0, '0);
      cyc(1);
      check("R8 reselect after gap", 1'b1, lowest(m1));
      req_n = '1;
      cyc(3);
      check("R9 zero after release", 1'b0, '0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule